// File: doc/BRIEF.md
# Bus Watchpoint Trigger Unit

The block sits beside a processor core and watches two buses: the instruction-fetch bus, which carries an address with a valid flag, and the load/store data bus, which carries an address, a data word, read and write qualifiers and a valid flag. It holds a bank of trigger slots. Each slot chooses one bus, a set of enabled match conditions, and an action. When all of the enabled conditions of a slot hold on a cycle where its bus is valid, the slot fires and its action is applied one clock later.

The actions are a break request to the debug logic, a one-cycle external trigger pulse, a trace-enable level that can be switched on and off, a one-cycle trace-sample strobe, and an arm action. The arm action opens a second rank of triggers, so a watchpoint can be made to fire only after some earlier event. Two adjacent slots can be joined so that the lower slot compares against an inclusive window bounded by its own values and those of the slot above it. Slots are loaded through a simple register write port.

Top module: `dbg_trig_unit`

## Requirements
- R1: A write with `cfgWe` high loads field `cfgField` of slot `cfgSlot`: field 0 is the control word, field 1 the address compare value, field 2 the data compare value. The control word bits are: bit 0 slot enable, bit 1 bus select (1 = data bus, 0 = instruction bus), bit 2 address match, bit 3 data match, bit 4 read match, bit 5 write match, bit 6 second-level (armed-only), bit 7 range, bits 10:8 action (0 none, 1 break, 2 external trigger, 3 trace on, 4 trace off, 5 trace sample, 6 arm).
- R2: A slot is evaluated only on cycles where the valid signal of its selected bus is high; with both valids low no output pulses and the trace level holds. Outputs reflect the inputs of the previous clock edge.
- R3: The address condition compares for equality with the address of the selected bus, and works on either bus.
- R4: Data-value, read and write conditions apply only to data-bus slots; on an instruction-bus slot those enable bits are ignored.
- R5: All enabled conditions of one slot are combined with logical AND; a slot with no condition enabled fires on every valid cycle of its bus.
- R6: With the range bit set on an even data-bus slot, its address and data conditions become inclusive window tests, the even slot holding the lower bound and the next odd slot the upper bound.
- R7: Break and external-trigger actions give a one-cycle pulse on `brkReq` and `extTrig` for each cycle a matching slot fires.
- R8: Trace on sets `traceEn` and trace off clears it; the level holds otherwise, and trace off wins when both fire on the same cycle.
- R9: The trace-sample action pulses `traceSample` only when fired by a data-bus slot; an instruction-bus slot with that action has no effect.
- R10: A second-level slot never fires until a first-level slot has executed the arm action; the arm action of a second-level slot does not arm.
- R11: The armed state persists until any configuration write or reset clears it.
- R12: After reset all outputs are low and every slot is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSlot | input | SW | Slot index to write |
| cfgField | input | 2 | Field select: control, address, data |
| cfgWdata | input | WW | Write data |
| iValid | input | 1 | Instruction bus valid |
| iAddr | input | AW | Instruction bus address |
| dValid | input | 1 | Data bus valid |
| dAddr | input | AW | Data bus address |
| dData | input | DW | Data bus data word |
| dRead | input | 1 | Data bus read cycle |
| dWrite | input | 1 | Data bus write cycle |
| brkReq | output | 1 | Break request pulse |
| extTrig | output | 1 | External trigger pulse |
| traceEn | output | 1 | Trace enable level |
| traceSample | output | 1 | Single trace sample strobe |

## Verification
On every cycle the assertions check that no break, external trigger or sample pulse appears and the trace level does not move unless a bus was valid on the previous edge, and that a sample strobe only follows a valid data-bus cycle. The combination of conditions, inclusive window bounds, trace-off priority, two-level arming with its clearing by configuration writes and reset, and the ignoring of data-only conditions on the instruction bus depend on programmed slot contents, so only the bench's scenarios can show them.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_BREAK  = 3'd1,
    ACT_EXT    = 3'd2,
    ACT_TRON   = 3'd3,
    ACT_TROFF  = 3'd4,
    ACT_SAMPLE = 3'd5,
    ACT_ARM    = 3'd6,
    ACT_RSVD   = 3'd7
  } trigAct_e;

  // Control word, LSB first: en, busData, addrEn, dataEn, rdEn, wrEn, armedOnly, rangeEn, act
  typedef struct packed {
    trigAct_e act;
    logic     rangeEn;
    logic     armedOnly;
    logic     wrEn;
    logic     rdEn;
    logic     dataEn;
    logic     addrEn;
    logic     busData;
    logic     en;
  } slotCtrl_t;

  localparam int CTRL_W = $bits(slotCtrl_t);

  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_ADDR = 2'd1;
  localparam logic [1:0] FLD_DATA = 2'd2;

  // Per-slot result handed from datapath to control
  typedef struct packed {
    logic     fire;
    trigAct_e act;
    logic     lvl2;
    logic     onData;
  } slotHit_t;

  // Strobes from control back to the datapath
  typedef struct packed {
    logic armed;
  } ctrlStrobe_t;

endpackage

// File: rtl/dbg_trig_dp.sv
module dbg_trig_dp
  import dbg_trig_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 3,
  parameter int WW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SW-1:0]     cfgSlot,
  input  logic [1:0]        cfgField,
  input  logic [WW-1:0]     cfgWdata,
  input  logic              iValid,
  input  logic [AW-1:0]     iAddr,
  input  logic              dValid,
  input  logic [AW-1:0]     dAddr,
  input  logic [DW-1:0]     dData,
  input  logic              dRead,
  input  logic              dWrite,
  input  ctrlStrobe_t       strb,
  output slotHit_t          hits [NUM_SLOTS]
);

  slotCtrl_t         ctrlReg [NUM_SLOTS];
  logic [AW-1:0]     addrCmp [NUM_SLOTS];
  logic [DW-1:0]     dataCmp [NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        ctrlReg[s] <= '0;
        addrCmp[s] <= '0;
        dataCmp[s] <= '0;
      end
    end else if (cfgWe) begin
      case (cfgField)
        FLD_CTRL: ctrlReg[cfgSlot] <= slotCtrl_t'(cfgWdata[CTRL_W-1:0]);
        FLD_ADDR: addrCmp[cfgSlot] <= cfgWdata[AW-1:0];
        FLD_DATA: dataCmp[cfgSlot] <= cfgWdata[DW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic          onData, busValid, useRange;
    logic [AW-1:0] busAddr;
    logic          addrEq, dataEq, addrIn, dataIn;
    logic          addrOk, dataOk, rdOk, wrOk, armOk;

    assign onData   = ctrlReg[i].busData;
    assign busValid = onData ? dValid : iValid;
    assign busAddr  = onData ? dAddr : iAddr;
    assign addrEq   = (busAddr == addrCmp[i]);
    assign dataEq   = (dData == dataCmp[i]);

    if ((i % 2 == 0) && (i + 1 < NUM_SLOTS)) begin : g_pair
      assign useRange = ctrlReg[i].rangeEn & onData;
      assign addrIn   = (busAddr >= addrCmp[i]) && (busAddr <= addrCmp[i+1]);
      assign dataIn   = (dData >= dataCmp[i]) && (dData <= dataCmp[i+1]);
    end else begin : g_single
      assign useRange = 1'b0;
      assign addrIn   = 1'b0;
      assign dataIn   = 1'b0;
    end

    assign addrOk = !ctrlReg[i].addrEn || (useRange ? addrIn : addrEq);
    assign dataOk = !(ctrlReg[i].dataEn && onData) || (useRange ? dataIn : dataEq);
    assign rdOk   = !(ctrlReg[i].rdEn && onData) || dRead;
    assign wrOk   = !(ctrlReg[i].wrEn && onData) || dWrite;
    assign armOk  = !ctrlReg[i].armedOnly || strb.armed;

    assign hits[i].fire   = ctrlReg[i].en && busValid && addrOk && dataOk
                            && rdOk && wrOk && armOk;
    assign hits[i].act    = ctrlReg[i].act;
    assign hits[i].lvl2   = ctrlReg[i].armedOnly;
    assign hits[i].onData = onData;
  end

endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  slotHit_t    hits [NUM_SLOTS],
  output ctrlStrobe_t strb,
  output logic        brkReq,
  output logic        extTrig,
  output logic        traceEn,
  output logic        traceSample
);

  logic doBrk, doExt, doOn, doOff, doSmp, doArm;
  logic armed;

  always_comb begin
    doBrk = 1'b0;
    doExt = 1'b0;
    doOn  = 1'b0;
    doOff = 1'b0;
    doSmp = 1'b0;
    doArm = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (hits[s].fire) begin
        case (hits[s].act)
          ACT_BREAK:  doBrk = 1'b1;
          ACT_EXT:    doExt = 1'b1;
          ACT_TRON:   doOn  = 1'b1;
          ACT_TROFF:  doOff = 1'b1;
          ACT_SAMPLE: if (hits[s].onData) doSmp = 1'b1;
          ACT_ARM:    if (!hits[s].lvl2)  doArm = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkReq      <= 1'b0;
      extTrig     <= 1'b0;
      traceEn     <= 1'b0;
      traceSample <= 1'b0;
      armed       <= 1'b0;
    end else begin
      brkReq      <= doBrk;
      extTrig     <= doExt;
      traceSample <= doSmp;
      if (doOff)      traceEn <= 1'b0;
      else if (doOn)  traceEn <= 1'b1;
      if (cfgWe)      armed <= 1'b0;
      else if (doArm) armed <= 1'b1;
    end
  end

  assign strb.armed = armed;

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int WW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgSlot,
  input  logic [1:0]    cfgField,
  input  logic [WW-1:0] cfgWdata,
  input  logic          iValid,
  input  logic [AW-1:0] iAddr,
  input  logic          dValid,
  input  logic [AW-1:0] dAddr,
  input  logic [DW-1:0] dData,
  input  logic          dRead,
  input  logic          dWrite,
  output logic          brkReq,
  output logic          extTrig,
  output logic          traceEn,
  output logic          traceSample
);

  slotHit_t    hits [NUM_SLOTS];
  ctrlStrobe_t strb;

  dbg_trig_dp #(
    .NUM_SLOTS(NUM_SLOTS), .AW(AW), .DW(DW), .SW(SW), .WW(WW)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgField(cfgField), .cfgWdata(cfgWdata),
    .iValid(iValid), .iAddr(iAddr),
    .dValid(dValid), .dAddr(dAddr), .dData(dData), .dRead(dRead), .dWrite(dWrite),
    .strb(strb), .hits(hits)
  );

  dbg_trig_ctrl #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .hits(hits), .strb(strb),
    .brkReq(brkReq), .extTrig(extTrig), .traceEn(traceEn), .traceSample(traceSample)
  );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
  input logic clk,
  input logic rstN,
  input logic iValid,
  input logic dValid,
  input logic brkReq,
  input logic extTrig,
  input logic traceEn,
  input logic traceSample
);

  // R2: no bus activity, no break
  p_idle_no_break_r2: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> $past(iValid || dValid));

  // R2: no bus activity, no external trigger
  p_idle_no_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    extTrig |-> $past(iValid || dValid));

  // R8 / R2: trace level only moves after a valid bus cycle
  p_trace_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(iValid || dValid) |=> $stable(traceEn));

  // R9: sample strobe only follows a valid data-bus cycle
  p_sample_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    traceSample |-> $past(dValid));

endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
  .clk(clk), .rstN(rstN), .iValid(iValid), .dValid(dValid),
  .brkReq(brkReq), .extTrig(extTrig), .traceEn(traceEn), .traceSample(traceSample)
);

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSlot = '0;
  logic [1:0]  cfgField = '0;
  logic [31:0] cfgWdata = '0;
  logic        iValid = 1'b0;
  logic [31:0] iAddr = '0;
  logic        dValid = 1'b0;
  logic [31:0] dAddr = '0;
  logic [31:0] dData = '0;
  logic        dRead = 1'b0;
  logic        dWrite = 1'b0;
  logic        brkReq, extTrig, traceEn, traceSample;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgField(cfgField),
    .cfgWdata(cfgWdata), .iValid(iValid), .iAddr(iAddr), .dValid(dValid),
    .dAddr(dAddr), .dData(dData), .dRead(dRead), .dWrite(dWrite),
    .brkReq(brkReq), .extTrig(extTrig), .traceEn(traceEn), .traceSample(traceSample)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        iv;
    logic [31:0] ia;
    logic        dv;
    logic [31:0] da;
    logic [31:0] dd;
    logic        rd;
    logic        wr;
    logic        eb, ee, et, es;
  } vec_t;

  function automatic vec_t mkv(input logic [3:0] req, input logic iv, input logic [31:0] ia,
                               input logic dv, input logic [31:0] da, input logic [31:0] dd,
                               input logic rd, input logic wr,
                               input logic eb, input logic ee, input logic et, input logic es);
    vec_t v;
    v.req = req; v.iv = iv; v.ia = ia; v.dv = dv; v.da = da; v.dd = dd;
    v.rd = rd; v.wr = wr; v.eb = eb; v.ee = ee; v.et = et; v.es = es;
    return v;
  endfunction

  // Expected outputs: break, ext, traceEn, sample
  localparam vec_t TBL [NV] = '{
    mkv(4'd2,  0, 32'h0,   0, 32'h0,   32'h0,    0, 0, 0, 0, 0, 0), // R2 idle
    mkv(4'd5,  0, 32'h0,   1, 32'h100, 32'h0,    0, 1, 1, 0, 0, 0), // R5 write to 0x100
    mkv(4'd5,  0, 32'h0,   1, 32'h100, 32'h0,    1, 0, 0, 0, 0, 0), // R5 read, AND fails
    mkv(4'd3,  0, 32'h0,   1, 32'h101, 32'h0,    0, 1, 0, 0, 0, 0), // R3 wrong address
    mkv(4'd3,  1, 32'h40,  0, 32'h0,   32'h0,    0, 0, 0, 1, 0, 0), // R3 instr address
    mkv(4'd2,  0, 32'h0,   1, 32'h40,  32'h0,    1, 0, 0, 0, 0, 0), // R2 wrong bus
    mkv(4'd6,  0, 32'h0,   1, 32'h200, 32'h0,    1, 0, 0, 0, 1, 0), // R6 lower bound
    mkv(4'd8,  0, 32'h0,   0, 32'h0,   32'h0,    0, 0, 0, 0, 1, 0), // R8 level holds
    mkv(4'd8,  0, 32'h0,   1, 32'h20F, 32'hDEAD, 0, 1, 0, 0, 0, 0), // R8 off wins
    mkv(4'd6,  0, 32'h0,   1, 32'h210, 32'h0,    1, 0, 0, 0, 0, 0), // R6 above window
    mkv(4'd6,  0, 32'h0,   1, 32'h20F, 32'h0,    1, 0, 0, 0, 1, 0), // R6 upper bound
    mkv(4'd4,  0, 32'h0,   1, 32'h0,   32'hDEAD, 0, 1, 0, 0, 0, 0), // R4 data value off
    mkv(4'd9,  0, 32'h0,   1, 32'h300, 32'h0,    1, 0, 0, 0, 0, 1), // R9 sample on read
    mkv(4'd4,  0, 32'h0,   1, 32'h300, 32'h0,    0, 1, 0, 0, 0, 0), // R4 write not read
    mkv(4'd10, 0, 32'h0,   1, 32'h400, 32'h0,    1, 0, 0, 0, 0, 0), // R10 not armed
    mkv(4'd10, 1, 32'h80,  0, 32'h0,   32'h0,    0, 0, 0, 0, 0, 0), // R10 arm event
    mkv(4'd10, 0, 32'h0,   1, 32'h400, 32'h0,    1, 0, 0, 1, 0, 0), // R10 armed fires
    mkv(4'd11, 0, 32'h0,   1, 32'h400, 32'h0,    1, 0, 0, 1, 0, 0), // R11 arm persists
    mkv(4'd7,  1, 32'h40,  1, 32'h100, 32'h0,    0, 1, 1, 1, 0, 0), // R7 both pulses
    mkv(4'd2,  0, 32'h40,  0, 32'h100, 32'h0,    0, 1, 0, 0, 0, 0)  // R2 valids low
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic en, input logic bus, input logic ae,
                                     input logic de, input logic re, input logic we,
                                     input logic l2, input logic rg, input logic [2:0] act);
    return {21'b0, act, rg, l2, we, re, de, ae, bus, en};
  endfunction

  task automatic cfgWr(input int slot, input logic [1:0] fld, input logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = 3'(slot); cfgField = fld; cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic busDrive(input logic iv, input logic [31:0] ia, input logic dv,
                          input logic [31:0] da, input logic [31:0] dd,
                          input logic rd, input logic wr);
    iValid = iv; iAddr = ia; dValid = dv; dAddr = da; dData = dd; dRead = rd; dWrite = wr;
  endtask

  task automatic stepIdle();
    busDrive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (2) @(negedge clk);
    check("R12", "brkReq in reset", brkReq, 1'b0);
    check("R12", "extTrig in reset", extTrig, 1'b0);
    check("R12", "traceEn in reset", traceEn, 1'b0);
    check("R12", "traceSample in reset", traceSample, 1'b0);
    rstN = 1'b1;

    // R1 slot programming
    cfgWr(0, 2'd1, 32'h100); cfgWr(0, 2'd0, cw(1,1,1,0,0,1,0,0,3'd1));
    cfgWr(1, 2'd1, 32'h40);  cfgWr(1, 2'd0, cw(1,0,1,0,0,0,0,0,3'd2));
    cfgWr(2, 2'd1, 32'h200); cfgWr(2, 2'd0, cw(1,1,1,0,0,0,0,1,3'd3));
    cfgWr(3, 2'd1, 32'h20F);
    cfgWr(4, 2'd2, 32'hDEAD); cfgWr(4, 2'd0, cw(1,1,0,1,0,0,0,0,3'd4));
    cfgWr(5, 2'd1, 32'h300); cfgWr(5, 2'd0, cw(1,1,1,0,1,0,0,0,3'd5));
    cfgWr(6, 2'd1, 32'h80);  cfgWr(6, 2'd0, cw(1,0,1,0,0,0,0,0,3'd6));
    cfgWr(7, 2'd1, 32'h400); cfgWr(7, 2'd0, cw(1,1,1,0,0,0,1,0,3'd2));
    stepIdle();

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[k].req, k);
      busDrive(TBL[k].iv, TBL[k].ia, TBL[k].dv, TBL[k].da, TBL[k].dd, TBL[k].rd, TBL[k].wr);
      @(negedge clk);
      check(tag, "brkReq", brkReq, TBL[k].eb);
      check(tag, "extTrig", extTrig, TBL[k].ee);
      check(tag, "traceEn", traceEn, TBL[k].et);
      check(tag, "traceSample", traceSample, TBL[k].es);
    end
    stepIdle();

    // R11: configuration write clears arm state
    cfgWr(5, 2'd2, 32'h0);
    busDrive(0, 0, 1, 32'h400, 0, 1, 0);
    @(negedge clk);
    check("R11", "extTrig after cfg write", extTrig, 1'b0);
    // re-arm and confirm reset clears it too
    busDrive(1, 32'h80, 0, 0, 0, 0, 0);
    @(negedge clk);
    busDrive(0, 0, 1, 32'h400, 0, 1, 0);
    @(negedge clk);
    check("R11", "extTrig after re-arm", extTrig, 1'b1);
    busDrive(0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R12", "extTrig during reset", extTrig, 1'b0);
    check("R12", "traceEn during reset", traceEn, 1'b0);
    rstN = 1'b1;
    busDrive(0, 0, 1, 32'h400, 0, 1, 0);
    @(negedge clk);
    check("R12", "slots cleared after reset", extTrig, 1'b0);
    busDrive(1, 32'h40, 1, 32'h100, 0, 0, 1);
    @(negedge clk);
    check("R12", "brkReq with cleared slots", brkReq, 1'b0);
    stepIdle();

    // R4: data-only conditions ignored on an instruction slot
    cfgWr(0, 2'd1, 32'h10); cfgWr(0, 2'd2, 32'h55);
    cfgWr(0, 2'd0, cw(1,0,1,1,1,1,0,0,3'd1));
    busDrive(1, 32'h10, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4", "instr slot ignores data/rd/wr", brkReq, 1'b1);

    // R9: sample action from an instruction slot does nothing
    cfgWr(1, 2'd1, 32'h20); cfgWr(1, 2'd0, cw(1,0,1,0,0,0,0,0,3'd5));
    busDrive(1, 32'h20, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9", "sample from instr slot", traceSample, 1'b0);

    // R10: arm action of a second-level slot does not arm
    cfgWr(2, 2'd1, 32'h30); cfgWr(2, 2'd0, cw(1,0,1,0,0,0,1,0,3'd6));
    cfgWr(3, 2'd1, 32'h500); cfgWr(3, 2'd0, cw(1,1,1,0,0,0,1,0,3'd1));
    busDrive(1, 32'h30, 0, 0, 0, 0, 0);
    @(negedge clk);
    busDrive(0, 0, 1, 32'h500, 0, 1, 0);
    @(negedge clk);
    check("R10", "level-two arm ignored", brkReq, 1'b0);

    // R5: slot with no conditions fires on every valid cycle
    cfgWr(4, 2'd0, cw(1,1,0,0,0,0,0,0,3'd2));
    busDrive(0, 0, 1, 32'h1234, 32'h9, 0, 0);
    @(negedge clk);
    check("R5", "unconditional slot", extTrig, 1'b1);
    stepIdle();
    check("R2", "idle after unconditional", extTrig, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule